// File: doc/BRIEF.md
# Tagged Slave Receive FIFO

This block holds the bytes that a remote bus master writes to the slave side of an SMBus controller. A slave bus engine outside the block offers each received byte as a one-cycle valid pulse. The pulse can carry a first mark (the byte right after the address match) and a last mark (the byte before stop or repeated start). The block stores each byte with a 2-bit frame-position tag. Software can then rebuild transaction boundaries from the FIFO contents alone.

Software drains the FIFO through a register pop. The read word always shows the head entry. A read strobe removes that entry, unless the FIFO is empty. An empty FIFO reads as tag 0, so the tag field also serves as the empty flag.

A control port lets software flush the FIFO and program a fill threshold, and it reads back the occupancy and the threshold. Level event outputs report a stored byte, a threshold reached and a full FIFO. A sticky flag records bytes that were dropped because the FIFO was full.

Occupancy is tracked by a three-state controller:
- EMPTY: the count is 0.
- FILL: the count is between 1 and DEPTH-1.
- FULL: the count equals DEPTH.

Its transitions are:
- `push_first`: EMPTY to FILL.
- `drain_last`: FILL to EMPTY, when the final entry is popped.
- `reach_top`: FILL to FULL, when a push lands on the last free slot.
- `pop_from_top`: FULL to FILL.
- `flush_clear`: any state to EMPTY.
- `hold`: stay in the current state, which covers a pop and a push in the same cycle.

Top module: `smb_tagged_rxq`

## Requirements
- R1: The read word carries the tag in bits 31:30 and the data in bits 7:0, with all other bits 0. The tag codes are 0 = FIFO empty, 1 = start of write, 2 = data byte, 3 = end of write.
- R2: A byte with the first mark is tagged 1. A byte with only the last mark is tagged 3. A byte with neither mark is tagged 2. A byte with both marks is tagged 1.
- R3: A read strobe while the FIFO is empty returns the word 0 and neither removes an entry nor changes the occupancy.
- R4: Entries leave in arrival order, one per read strobe, and the FIFO holds 64 entries.
- R5: The control read word has the occupancy in bits 22:16 and the threshold in bits 13:8, with all other bits 0.
- R6: A control write with bit 31 set empties the FIFO by the next cycle and clears the overflow flag. It overrides a push and a pop presented in the same cycle.
- R7: Bit 30 of a control write leaves the stored entries and the occupancy unchanged.
- R8: `evt_byte` is high exactly when the occupancy is nonzero.
- R9: `evt_thresh` is high exactly when the threshold is nonzero and the occupancy is at least the threshold. Every control write loads the threshold from bits 13:8.
- R10: `evt_full` is high exactly when the occupancy is 64.
- R11: A byte that arrives while the FIFO is full, with no pop in the same cycle, is dropped and sets `overflow`. The flag stays set until a flush. A push together with a pop on a full FIFO accepts both.
- R12: After reset the FIFO is empty, the threshold is 0, and all events and `overflow` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | One-cycle pulse: a received byte is offered |
| in_first | input | 1 | The offered byte follows the address match |
| in_last | input | 1 | The offered byte precedes stop or repeated start |
| in_data | input | 8 | Received byte |
| rd_strobe | input | 1 | Register read: removes the head entry |
| rd_word | output | 32 | Head entry view (tag and data) |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 32 | Control write data: receive flush, transmit flush, threshold |
| ctl_rdata | output | 32 | Control read data: occupancy and threshold |
| evt_byte | output | 1 | At least one entry is stored |
| evt_thresh | output | 1 | Occupancy has reached the nonzero threshold |
| evt_full | output | 1 | FIFO is full |
| overflow | output | 1 | Sticky: a byte was dropped while full |

## Verification
Three functions can land in the same clock edge: a push from the bus engine, a pop from the register read, and a flush from a control write. The bench drives these collisions in one cycle.

In the first collision, a push and a pop arrive while the FIFO is full. The bench judges it by the popped word, an unchanged count of 64, and a later drain order that ends with the new byte. In the second, a flush arrives together with a push and a pop. The bench judges it by a zero occupancy, an empty read word and a low byte event on the following cycle.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    localparam int BYTE_W       = 8;
    localparam int TAG_LSB      = 30;
    localparam int RX_FLUSH_BIT = 31;
    localparam int TX_FLUSH_BIT = 30;
    localparam int CNT_LSB      = 16;
    localparam int THR_LSB      = 8;

    typedef enum logic [1:0] {
        TAG_NONE  = 2'd0,
        TAG_START = 2'd1,
        TAG_MID   = 2'd2,
        TAG_END   = 2'd3
    } rxq_tag_e;

    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_FILL  = 2'd1,
        ST_FULL  = 2'd2
    } rxq_state_e;

    typedef struct packed {
        rxq_tag_e           tag;
        logic [BYTE_W-1:0]  data;
    } rxq_entry_t;
endpackage

// File: rtl/rxq_tagger.sv
module rxq_tagger
    import rxq_pkg::*;
#(
    parameter bit START_WINS = 1'b1
) (
    input  logic               first,
    input  logic               last,
    input  logic [BYTE_W-1:0]  data,
    output rxq_entry_t         entry
);
    rxq_tag_e tag;

    generate
        if (START_WINS) begin : g_start_wins
            always_comb begin
                if (first)      tag = TAG_START;
                else if (last)  tag = TAG_END;
                else            tag = TAG_MID;
            end
        end else begin : g_end_wins
            always_comb begin
                if (last)       tag = TAG_END;
                else if (first) tag = TAG_START;
                else            tag = TAG_MID;
            end
        end
    endgenerate

    always_comb begin
        entry.tag  = tag;
        entry.data = data;
    end

    // R2: a stored entry never carries the empty code
    always_comb begin
        assert_tag_nonzero_R2: assert (tag != TAG_NONE);
    end
endmodule

// File: rtl/rxq_store.sv
module rxq_store
    import rxq_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        flush,
    input  logic        wr_en,
    input  rxq_entry_t  wr_entry,
    input  logic        rd_en,
    output rxq_entry_t  head
);
    rxq_entry_t mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (wr_en) wr_ptr <= wr_ptr + AW'(1);
            if (rd_en) rd_ptr <= rd_ptr + AW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_ptr] <= wr_entry;
    end

    assign head = mem[rd_ptr];
endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
    import rxq_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_req,
    input  logic          pop_req,
    input  logic          flush,
    output logic          do_push,
    output logic          do_pop,
    output logic [CW-1:0] count,
    output logic          overflow,
    output rxq_state_e    state
);
    rxq_state_e    state_nxt;
    logic [CW-1:0] cnt_nxt;
    logic          drop;

    // output process: accepted operations
    always_comb begin
        do_pop  = pop_req && (state != ST_EMPTY) && !flush;
        do_push = push_req && !flush && ((state != ST_FULL) || do_pop);
        drop    = push_req && !flush && (state == ST_FULL) && !do_pop;
        if (flush) cnt_nxt = '0;
        else       cnt_nxt = count + CW'(do_push) - CW'(do_pop);
    end

    // next-state selection
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_EMPTY: begin
                if (do_push) state_nxt = ST_FILL;                     // push_first
            end
            ST_FILL: begin
                if (flush)                           state_nxt = ST_EMPTY; // flush_clear
                else if (cnt_nxt == '0)              state_nxt = ST_EMPTY; // drain_last
                else if (cnt_nxt == CW'(DEPTH))      state_nxt = ST_FULL;  // reach_top
            end
            ST_FULL: begin
                if (flush)                    state_nxt = ST_EMPTY;   // flush_clear
                else if (do_pop && !do_push)  state_nxt = ST_FILL;    // pop_from_top
            end
            default: state_nxt = ST_EMPTY;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_EMPTY;
        else        state <= state_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count    <= '0;
            overflow <= 1'b0;
        end else begin
            count <= cnt_nxt;
            if (flush)     overflow <= 1'b0;
            else if (drop) overflow <= 1'b1;
        end
    end

    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    assert_empty_state_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EMPTY) |-> (count == '0));
    assert_full_state_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FULL) |-> (count == CW'(DEPTH)));
    assert_empty_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && !push_req && !flush && count == '0) |=> (count == '0));
    assert_flush_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count == '0 && !overflow));
    assert_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !flush) |=> overflow);
    assert_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && !pop_req && !flush && count == CW'(DEPTH)) |=> (overflow && $stable(count)));
endmodule

// File: rtl/rxq_events.sv
module rxq_events #(
    parameter int DEPTH = 64,
    parameter int TW    = 6,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic [CW-1:0] count,
    input  logic [TW-1:0] thr,
    output logic          evt_byte,
    output logic          evt_thresh,
    output logic          evt_full
);
    always_comb begin
        evt_byte   = (count != '0);
        evt_thresh = (thr != '0) && (count >= CW'(thr));
        evt_full   = (count == CW'(DEPTH));
    end
endmodule

// File: rtl/smb_tagged_rxq.sv
module smb_tagged_rxq
    import rxq_pkg::*;
#(
    parameter int DEPTH      = 64,
    parameter int TW         = 6,
    parameter bit START_WINS = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic        in_first,
    input  logic        in_last,
    input  logic [7:0]  in_data,
    input  logic        rd_strobe,
    output logic [31:0] rd_word,
    input  logic        ctl_wr,
    input  logic [31:0] ctl_wdata,
    output logic [31:0] ctl_rdata,
    output logic        evt_byte,
    output logic        evt_thresh,
    output logic        evt_full,
    output logic        overflow
);
    localparam int CW = $clog2(DEPTH + 1);

    rxq_entry_t    in_entry;
    rxq_entry_t    head;
    rxq_state_e    state;
    logic          do_push;
    logic          do_pop;
    logic          flush;
    logic [CW-1:0] count;
    logic [TW-1:0] thr;

    assign flush = ctl_wr && ctl_wdata[RX_FLUSH_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      thr <= '0;
        else if (ctl_wr) thr <= ctl_wdata[THR_LSB +: TW];
    end

    rxq_tagger #(.START_WINS(START_WINS)) u_tag (
        .first (in_first),
        .last  (in_last),
        .data  (in_data),
        .entry (in_entry)
    );

    rxq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_req (in_valid),
        .pop_req  (rd_strobe),
        .flush    (flush),
        .do_push  (do_push),
        .do_pop   (do_pop),
        .count    (count),
        .overflow (overflow),
        .state    (state)
    );

    rxq_store #(.DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .wr_en    (do_push),
        .wr_entry (in_entry),
        .rd_en    (do_pop),
        .head     (head)
    );

    rxq_events #(.DEPTH(DEPTH), .TW(TW)) u_evt (
        .count      (count),
        .thr        (thr),
        .evt_byte   (evt_byte),
        .evt_thresh (evt_thresh),
        .evt_full   (evt_full)
    );

    always_comb begin
        rd_word = '0;
        if (state != ST_EMPTY) begin
            rd_word[TAG_LSB +: 2]  = head.tag;
            rd_word[BYTE_W-1:0]    = head.data;
        end
        ctl_rdata = '0;
        ctl_rdata[CNT_LSB +: CW] = count;
        ctl_rdata[THR_LSB +: TW] = thr;
    end

    assert_read_tag_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (count != '0) |-> (rd_word[31:30] != 2'd0));
    assert_evt_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
        evt_full |-> evt_byte);
endmodule

// File: tb/sim_smb_tagged_rxq.sv
module sim_smb_tagged_rxq;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, in_first = 1'b0, in_last = 1'b0;
    logic [7:0]  in_data = '0;
    logic        rd_strobe = 1'b0;
    logic [31:0] rd_word;
    logic        ctl_wr = 1'b0;
    logic [31:0] ctl_wdata = '0;
    logic [31:0] ctl_rdata;
    logic        evt_byte, evt_thresh, evt_full, overflow;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    smb_tagged_rxq u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_first(in_first),
        .in_last(in_last), .in_data(in_data), .rd_strobe(rd_strobe),
        .rd_word(rd_word), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .ctl_rdata(ctl_rdata), .evt_byte(evt_byte), .evt_thresh(evt_thresh),
        .evt_full(evt_full), .overflow(overflow)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic push(input logic f, input logic l, input logic [7:0] d);
        in_valid = 1'b1; in_first = f; in_last = l; in_data = d;
        @(posedge clk); #1;
        in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0;
    endtask

    task automatic pop(output logic [31:0] w);
        w = rd_word;
        rd_strobe = 1'b1;
        @(posedge clk); #1;
        rd_strobe = 1'b0;
    endtask

    task automatic ctl(input logic [31:0] wd);
        ctl_wr = 1'b1; ctl_wdata = wd;
        @(posedge clk); #1;
        ctl_wr = 1'b0; ctl_wdata = '0;
    endtask

    task automatic t_reset;
        chk("R12 rd_word", rd_word, 32'h0);
        chk("R12 ctl_rdata", ctl_rdata, 32'h0);
        chk("R12 events", {28'h0, evt_byte, evt_thresh, evt_full, overflow}, 32'h0);
    endtask

    task automatic t_tags;
        logic [31:0] w;
        push(1, 0, 8'hA5); push(0, 0, 8'h3C); push(0, 1, 8'h7E); push(1, 1, 8'h11);
        chk("R5 count after four", ctl_rdata, 32'h0004_0000);
        chk("R8 byte event", {31'h0, evt_byte}, 32'h1);
        pop(w); chk("R1 R2 start tag", w, 32'h4000_00A5);
        pop(w); chk("R2 data tag", w, 32'h8000_003C);
        pop(w); chk("R2 end tag", w, 32'hC000_007E);
        pop(w); chk("R2 both marks", w, 32'h4000_0011);
        chk("R8 byte event off", {31'h0, evt_byte}, 32'h0);
    endtask

    task automatic t_empty_read;
        logic [31:0] w;
        pop(w); chk("R3 empty word", w, 32'h0);
        chk("R3 count held", ctl_rdata, 32'h0);
        push(0, 1, 8'h5A);
        pop(w); chk("R3 no stray pop", w, 32'hC000_005A);
    endtask

    task automatic t_thresh;
        ctl(32'h0000_0300);
        chk("R5 threshold field", ctl_rdata, 32'h0000_0300);
        push(1, 0, 8'h01); push(0, 0, 8'h02);
        chk("R9 below", {31'h0, evt_thresh}, 32'h0);
        push(0, 1, 8'h03);
        chk("R9 reached", {31'h0, evt_thresh}, 32'h1);
        chk("R5 count and thr", ctl_rdata, 32'h0003_0300);
        ctl(32'h0000_0000);
        chk("R9 zero threshold", {31'h0, evt_thresh}, 32'h0);
        ctl(32'h8000_0000);
        chk("R6 flush count", ctl_rdata, 32'h0);
    endtask

    task automatic t_full;
        logic [31:0] w;
        for (int i = 0; i < 64; i++) push(i == 0, 1'b0, 8'(i));
        chk("R10 full event", {31'h0, evt_full}, 32'h1);
        chk("R4 count 64", ctl_rdata, 32'h0040_0000);
        chk("R11 no overflow yet", {31'h0, overflow}, 32'h0);
        push(0, 0, 8'hEE);
        chk("R11 overflow set", {31'h0, overflow}, 32'h1);
        chk("R11 count held", ctl_rdata, 32'h0040_0000);
        // push and pop in the same cycle while full
        w = rd_word;
        in_valid = 1'b1; in_data = 8'h99; rd_strobe = 1'b1;
        @(posedge clk); #1;
        in_valid = 1'b0; rd_strobe = 1'b0;
        chk("R11 pop at full", w, 32'h4000_0000);
        chk("R11 count after both", ctl_rdata, 32'h0040_0000);
        for (int i = 1; i < 64; i++) begin
            pop(w);
            if (w !== (32'h8000_0000 | 32'(i))) chk("R4 drain order", w, 32'h8000_0000 | 32'(i));
            else total++;
        end
        pop(w); chk("R4 R11 last accepted", w, 32'h8000_0099);
        chk("R10 not full", {31'h0, evt_full}, 32'h0);
        chk("R11 sticky", {31'h0, overflow}, 32'h1);
        ctl(32'h8000_0000);
        chk("R6 overflow cleared", {31'h0, overflow}, 32'h0);
    endtask

    task automatic t_flush_collide;
        push(1, 0, 8'h21); push(0, 0, 8'h22);
        ctl_wr = 1'b1; ctl_wdata = 32'h8000_0000;
        in_valid = 1'b1; in_data = 8'h23; rd_strobe = 1'b1;
        @(posedge clk); #1;
        ctl_wr = 1'b0; ctl_wdata = '0; in_valid = 1'b0; rd_strobe = 1'b0;
        chk("R6 count zero", ctl_rdata, 32'h0);
        chk("R6 rd_word empty", rd_word, 32'h0);
        chk("R6 R8 byte event", {31'h0, evt_byte}, 32'h0);
    endtask

    task automatic t_txflush;
        logic [31:0] w;
        push(1, 1, 8'h44);
        ctl(32'h4000_0000);
        chk("R7 count kept", ctl_rdata, 32'h0001_0000);
        pop(w); chk("R7 entry kept", w, 32'h4000_0044);
    endtask

    task automatic t_push_pop;
        logic [31:0] w;
        push(1, 0, 8'h61);
        w = rd_word;
        in_valid = 1'b1; in_last = 1'b1; in_data = 8'h62; rd_strobe = 1'b1;
        @(posedge clk); #1;
        in_valid = 1'b0; in_last = 1'b0; rd_strobe = 1'b0;
        chk("R4 popped head", w, 32'h4000_0061);
        chk("R4 count one", ctl_rdata, 32'h0001_0000);
        pop(w); chk("R4 new head", w, 32'hC000_0062);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        bad++; total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 2 + 1);
        rst_n = 1'b1;
        @(posedge clk); #1;
        t_reset();
        t_tags();
        t_empty_read();
        t_thresh();
        t_full();
        t_flush_collide();
        t_txflush();
        t_push_pop();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule